// File: doc/BRIEF.md
# Linked-List Command DMA Walker

This block is a DMA channel that walks a chain of command packets held in system memory and streams each packet's payload words to a graphics command port. Every node begins with one header word: the top byte gives how many 32-bit payload words follow it, and the low 24 bits point at the next node. Software starts the channel with a start address and a control word. The walker then fetches headers, forwards payloads in order, follows the pointers and stops when a pointer carries the end flag.

Because a corrupt list can loop or run on for a very long time, the walker keeps a three-entry address history that catches cycles. It also has a node budget that abandons a walk which never ends. When a walk finishes for any reason, the channel drops its active flag and pulses an interrupt. It then reports the total number of list words consumed, the final address register value and the cause of the stop. A graphics-ready flag is held low for the whole walk.

Memory is a plain read port with a fixed latency of one cycle: data for a read issued in one cycle is present in the next. Arbitration and command decoding sit outside the block.

Top module: `ll_dma_walker`

## Requirements
- R1: A start pulse launches a walk only when the control input equals 0x01000401 and the channel is idle. Any other control value has no effect: there are no memory reads, `chan_active_o` stays 0 and there is no interrupt.
- R2: Before use, every node address is ANDed with 0x1FFFFC, and the header is read at that byte address. The first node is always visited, even when bit 23 of the start address is set.
- R3: Header bits 31:24 give N, the payload word count (0 to 255). The N words at byte addresses node+4 to node+4N are presented on `cmd_data_o` in ascending address order, one per `cmd_valid_o` cycle.
- R4: Header bits 23:0 are the next-node pointer. After a node's payload, a pointer with bit 23 set ends the walk. `cur_addr_o` then holds that pointer unchanged and `stop_cause_o` is 0.
- R5: Three history registers start at 0xFFFFFF: last, low and high. A masked address equal to low or high stops the walk with `stop_cause_o` = 1 and `cur_addr_o` set to that masked address. Otherwise the address goes to low if it is below last and to high if it is not, and then becomes last.
- R6: When a node is about to be visited and more than MAX_NODES nodes have already been visited, the walk stops with `stop_cause_o` = 2 and `cur_addr_o` set to the masked address. At most MAX_NODES+1 nodes are processed.
- R7: `total_words_o` equals 1 plus, for each processed node, 1 + N.
- R8: `gpu_ready_o` is 0 while a walk is active and 1 otherwise, including after reset.
- R9: When a walk stops, `chan_active_o` falls and `irq_o` is high for exactly one cycle. The result outputs update on that same cycle.
- R10: After reset, `chan_active_o`, `irq_o` and `cmd_valid_o` are 0, and `total_words_o` and `cur_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| ctrl_i | input | 32 | Channel control word sampled with start |
| start_addr_i | input | 24 | Address of the first node |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 21 | Byte address of the read, word aligned |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the strobe |
| cmd_valid_o | output | 1 | Payload word valid |
| cmd_data_o | output | 32 | Payload word to the graphics port |
| chan_active_o | output | 1 | Channel busy flag |
| gpu_ready_o | output | 1 | Graphics-ready status, low during a walk |
| irq_o | output | 1 | One-cycle completion pulse |
| cur_addr_o | output | 24 | Address register after the walk |
| total_words_o | output | 32 | List words consumed by the last walk |
| stop_cause_o | output | 2 | 0 end flag, 1 cycle found, 2 node budget spent |

## Verification
The hardest stops to reach are the two aborts. A cycle is caught only when an address repeats the current low or high history entry, which depends on the order in which earlier nodes were visited. The budget abort needs a list longer than the budget with no repeated address. The bench builds lists in ascending, descending and zigzag placement, with and without a back-pointer into the middle of the chain, for every length up to beyond a budget of five. A reference walker in the bench predicts the stop cause, the final address, the word total and the payload stream for each list.

// File: rtl/llw_pkg.sv
package llw_pkg;
    localparam logic [31:0] LL_CTRL   = 32'h0100_0401;
    localparam logic [23:0] ADDR_MASK = 24'h1F_FFFC;

    typedef enum logic [1:0] {
        STOP_END  = 2'd0,
        STOP_LOOP = 2'd1,
        STOP_CAP  = 2'd2
    } stop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VISIT,
        ST_HDR,
        ST_PAY,
        ST_AFTER
    } state_e;
endpackage

// File: rtl/llw_loop_guard.sv
module llw_loop_guard #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          commit_i,
    input  logic [AW-1:0] probe_i,
    output logic          hit_o
);
    localparam logic [AW-1:0] INIT = {AW{1'b1}};

    typedef struct packed {
        logic [AW-1:0] last;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d   = h_q;
        hit_o = (probe_i == h_q.lo) || (probe_i == h_q.hi);
        if (clear_i) begin
            h_d.last = INIT;
            h_d.lo   = INIT;
            h_d.hi   = INIT;
        end else if (commit_i) begin
            if (probe_i < h_q.last) h_d.lo = probe_i;
            else                    h_d.hi = probe_i;
            h_d.last = probe_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.last <= INIT;
            h_q.lo   <= INIT;
            h_q.hi   <= INIT;
        end else begin
            h_q <= h_d;
        end
    end
endmodule

// File: rtl/llw_node_cap.sv
module llw_node_cap #(
    parameter int MAX_NODES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic over_o
);
    localparam int CW = $clog2(MAX_NODES + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_NODES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        over_o = (cnt_q > LIMIT);
        if (clear_i)                cnt_d = '0;
        else if (inc_i && !over_o)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker
    import llw_pkg::*;
#(
    parameter int MAX_NODES = 2000000,
    parameter int PA_W      = 21,
    parameter int LEN_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] ctrl_i,
    input  logic [23:0] start_addr_i,
    output logic        mem_rd_o,
    output logic [20:0] mem_addr_o,
    input  logic [31:0] mem_rdata_i,
    output logic        cmd_valid_o,
    output logic [31:0] cmd_data_o,
    output logic        chan_active_o,
    output logic        gpu_ready_o,
    output logic        irq_o,
    output logic [23:0] cur_addr_o,
    output logic [31:0] total_words_o,
    output logic [1:0]  stop_cause_o
);
    localparam int IDX_W = LEN_W + 1;

    typedef struct packed {
        state_e            st;
        logic [23:0]       addr;
        logic [PA_W-1:0]   base;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic [31:0]       total;
        logic              active;
        logic              ready;
        logic              irq;
        logic              pend;
        stop_e             cause;
    } walk_t;

    walk_t w_d, w_q;

    logic        g_clear, g_commit, g_hit;
    logic        c_inc, c_over;
    logic [23:0] masked;
    logic [IDX_W-1:0] idx_nx;

    llw_loop_guard #(.AW(24)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (g_clear),
        .commit_i (g_commit),
        .probe_i  (masked),
        .hit_o    (g_hit)
    );

    llw_node_cap #(.MAX_NODES(MAX_NODES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (g_clear),
        .inc_i   (c_inc),
        .over_o  (c_over)
    );

    always_comb begin
        w_d        = w_q;
        w_d.irq    = 1'b0;
        w_d.pend   = 1'b0;
        mem_rd_o   = 1'b0;
        mem_addr_o = '0;
        g_clear    = 1'b0;
        g_commit   = 1'b0;
        c_inc      = 1'b0;
        masked     = w_q.addr & ADDR_MASK;
        idx_nx     = {1'b0, w_q.idx} + 1'b1;

        case (w_q.st)
            ST_IDLE: begin
                if (start_i && ctrl_i == LL_CTRL) begin
                    w_d.st     = ST_VISIT;
                    w_d.addr   = start_addr_i;
                    w_d.active = 1'b1;
                    w_d.ready  = 1'b0;
                    w_d.total  = 32'd1;
                    g_clear    = 1'b1;
                end
            end
            ST_VISIT: begin
                if (c_over || g_hit) begin
                    w_d.st     = ST_IDLE;
                    w_d.active = 1'b0;
                    w_d.ready  = 1'b1;
                    w_d.irq    = 1'b1;
                    w_d.addr   = masked;
                    w_d.cause  = c_over ? STOP_CAP : STOP_LOOP;
                end else begin
                    g_commit   = 1'b1;
                    c_inc      = 1'b1;
                    mem_rd_o   = 1'b1;
                    mem_addr_o = masked[PA_W-1:0];
                    w_d.base   = masked[PA_W-1:0];
                    w_d.st     = ST_HDR;
                end
            end
            ST_HDR: begin
                w_d.len   = mem_rdata_i[31:24];
                w_d.addr  = mem_rdata_i[23:0];
                w_d.total = w_q.total + 32'd1 + 32'(mem_rdata_i[31:24]);
                w_d.idx   = '0;
                w_d.st    = (mem_rdata_i[31:24] == '0) ? ST_AFTER : ST_PAY;
            end
            ST_PAY: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = w_q.base + PA_W'({idx_nx, 2'b00});
                w_d.pend   = 1'b1;
                w_d.idx    = idx_nx[LEN_W-1:0];
                if (idx_nx == {1'b0, w_q.len}) w_d.st = ST_AFTER;
            end
            ST_AFTER: begin
                if (w_q.addr[23]) begin
                    w_d.st     = ST_IDLE;
                    w_d.active = 1'b0;
                    w_d.ready  = 1'b1;
                    w_d.irq    = 1'b1;
                    w_d.cause  = STOP_END;
                end else begin
                    w_d.st = ST_VISIT;
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.st     <= ST_IDLE;
            w_q.addr   <= '0;
            w_q.base   <= '0;
            w_q.len    <= '0;
            w_q.idx    <= '0;
            w_q.total  <= '0;
            w_q.active <= 1'b0;
            w_q.ready  <= 1'b1;
            w_q.irq    <= 1'b0;
            w_q.pend   <= 1'b0;
            w_q.cause  <= STOP_END;
        end else begin
            w_q <= w_d;
        end
    end

    assign cmd_valid_o   = w_q.pend;
    assign cmd_data_o    = mem_rdata_i;
    assign chan_active_o = w_q.active;
    assign gpu_ready_o   = w_q.ready;
    assign irq_o         = w_q.irq;
    assign cur_addr_o    = w_q.addr;
    assign total_words_o = w_q.total;
    assign stop_cause_o  = w_q.cause;
endmodule

module llw_walker_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] ctrl_i,
    input logic        mem_rd_o,
    input logic [20:0] mem_addr_o,
    input logic        cmd_valid_o,
    input logic        chan_active_o,
    input logic        gpu_ready_o,
    input logic        irq_o,
    input logic [23:0] cur_addr_o,
    input logic [1:0]  stop_cause_o
);
    // R1: a walk begins only after a start with the linked-list control word
    a_r1_start_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_active_o) |-> $past(start_i && ctrl_i == 32'h0100_0401));

    // R2: every read address is word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (mem_addr_o[1:0] == 2'b00));

    // R3: payload words only follow a read in the previous cycle
    a_r3_valid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(mem_rd_o));

    // R4: a normal end leaves a pointer with bit 23 set
    a_r4_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && stop_cause_o == 2'd0) |-> cur_addr_o[23]);

    // R8: graphics-ready is low whenever the channel is active
    a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        chan_active_o |-> !gpu_ready_o);

    // R9: the interrupt comes with the fall of the active flag and lasts one cycle
    a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!chan_active_o && $past(chan_active_o)));
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

bind ll_dma_walker llw_walker_checks u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .ctrl_i        (ctrl_i),
    .mem_rd_o      (mem_rd_o),
    .mem_addr_o    (mem_addr_o),
    .cmd_valid_o   (cmd_valid_o),
    .chan_active_o (chan_active_o),
    .gpu_ready_o   (gpu_ready_o),
    .irq_o         (irq_o),
    .cur_addr_o    (cur_addr_o),
    .stop_cause_o  (stop_cause_o)
);

// File: tb/ll_dma_walker_test.sv
module ll_dma_walker_test;
    localparam int CAP = 5;
    localparam int MEMW = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ctrl_i = '0;
    logic [23:0] start_addr_i = '0;
    logic        mem_rd_o;
    logic [20:0] mem_addr_o;
    logic [31:0] mem_rdata_i = '0;
    logic        cmd_valid_o;
    logic [31:0] cmd_data_o;
    logic        chan_active_o, gpu_ready_o, irq_o;
    logic [23:0] cur_addr_o;
    logic [31:0] total_words_o;
    logic [1:0]  stop_cause_o;

    always #4 clk = ~clk;

    ll_dma_walker #(.MAX_NODES(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
        .start_addr_i(start_addr_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o),
        .chan_active_o(chan_active_o), .gpu_ready_o(gpu_ready_o), .irq_o(irq_o),
        .cur_addr_o(cur_addr_o), .total_words_o(total_words_o), .stop_cause_o(stop_cause_o)
    );

    logic [31:0] mem [MEMW];
    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[13:2]];

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] exp_q [2048];
    int exp_n, got_n, stream_bad, irq_cnt, rd_cnt, ready_bad, first_rd_seen;
    logic [20:0] first_rd;
    logic [31:0] exp_total;
    logic [23:0] exp_addr;
    logic [1:0]  exp_cause;

    always @(negedge clk) begin
        if (cmd_valid_o) begin
            if (got_n >= exp_n || cmd_data_o !== exp_q[got_n]) stream_bad++;
            got_n++;
        end
        if (irq_o) irq_cnt++;
        if (mem_rd_o) begin
            rd_cnt++;
            if (!first_rd_seen) begin first_rd = mem_addr_o; first_rd_seen = 1; end
        end
        if (chan_active_o && gpu_ready_o) ready_bad++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference walker built from the requirements
    task automatic model(input logic [23:0] start);
        logic [23:0] a, m, last, lo, hi;
        logic [31:0] hdr;
        int cnt, n;
        a = start; last = 24'hFFFFFF; lo = last; hi = last;
        cnt = 0; exp_total = 1; exp_n = 0;
        forever begin
            m = a & 24'h1FFFFC;
            if (cnt > CAP) begin exp_cause = 2; exp_addr = m; break; end
            if (m == lo || m == hi) begin exp_cause = 1; exp_addr = m; break; end
            if (m < last) lo = m; else hi = m;
            last = m;
            cnt++;
            hdr = mem[m[13:2]];
            n = int'(hdr[31:24]);
            exp_total += 32'(1 + n);
            for (int j = 1; j <= n; j++) begin
                logic [20:0] pa;
                pa = m[20:0] + 21'(4 * j);
                exp_q[exp_n] = mem[pa[13:2]];
                exp_n++;
            end
            a = hdr[23:0];
            if (a[23]) begin exp_cause = 0; exp_addr = a; break; end
        end
    endtask

    task automatic run(input logic [23:0] start, input string tag);
        int t;
        model(start);
        got_n = 0; stream_bad = 0; irq_cnt = 0; ready_bad = 0; first_rd_seen = 0;
        @(negedge clk);
        start_i = 1; ctrl_i = 32'h0100_0401; start_addr_i = start;
        @(negedge clk);
        start_i = 0; ctrl_i = '0;
        t = 0;
        while (!irq_o && t < 5000) begin @(negedge clk); t++; end
        chk(irq_o === 1'b1, {"R9 irq ", tag}, {31'd0, irq_o}, 1);
        chk(stop_cause_o == exp_cause, {"R4/R5/R6 cause ", tag}, {30'd0, stop_cause_o}, {30'd0, exp_cause});
        chk(cur_addr_o == exp_addr, {"R4/R5/R6 addr ", tag}, {8'd0, cur_addr_o}, {8'd0, exp_addr});
        chk(total_words_o == exp_total, {"R7 total ", tag}, total_words_o, exp_total);
        chk(!chan_active_o && gpu_ready_o, {"R8 ready ", tag}, {30'd0, chan_active_o, gpu_ready_o}, 1);
        repeat (3) @(negedge clk);
        chk(stream_bad == 0 && got_n == exp_n, {"R3 stream ", tag}, 32'(got_n), 32'(exp_n));
        chk(irq_cnt == 1, {"R9 single pulse ", tag}, 32'(irq_cnt), 1);
        chk(ready_bad == 0, {"R8 low during walk ", tag}, 32'(ready_bad), 0);
        chk(first_rd == ((start & 24'h1FFFFC) & 24'h1FFFFF), {"R2 first read ", tag},
            {11'd0, first_rd}, {8'd0, start & 24'h1FFFFC});
    endtask

    function automatic logic [23:0] slot_addr(input int kind, input int i, input int n);
        int s;
        case (kind)
            0: s = i;
            1: s = n - 1 - i;
            default: s = (i % 2) ? (8 + i) : i;
        endcase
        return 24'(32'h400 + 32'h40 * s);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEMW; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!chan_active_o && !irq_o && !cmd_valid_o, "R10 flags", {29'd0, chan_active_o, irq_o, cmd_valid_o}, 0);
        chk(total_words_o == 0 && cur_addr_o == 0, "R10 results", total_words_o, 0);
        chk(gpu_ready_o === 1'b1, "R8 ready after reset", {31'd0, gpu_ready_o}, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1: wrong control words do nothing
        rd_cnt = 0; irq_cnt = 0;
        foreach (ctrl_i[k]) begin end
        for (int v = 0; v < 3; v++) begin
            @(negedge clk);
            start_i = 1; start_addr_i = 24'h000400;
            ctrl_i = (v == 0) ? 32'h0100_0201 : (v == 1) ? 32'h0100_0400 : 32'h0000_0401;
            @(negedge clk);
            start_i = 0;
            repeat (10) begin
                @(negedge clk);
                if (chan_active_o) rd_cnt += 100;
            end
        end
        chk(rd_cnt == 0 && irq_cnt == 0, "R1 ignored control", 32'(rd_cnt + irq_cnt), 0);

        // R4: end flag other than all ones; R2: masked start with bit 23 set
        mem[32'h100 >> 2] = 32'h02_000200;
        mem[32'h104 >> 2] = 32'h1111_0001;
        mem[32'h108 >> 2] = 32'h1111_0002;
        mem[32'h200 >> 2] = 32'h00_000300;
        mem[32'h300 >> 2] = 32'h03_8ABCDE;
        for (int j = 1; j <= 3; j++) mem[(32'h300 >> 2) + j] = 32'h3333_0000 + 32'(j);
        run(24'hE00103, "masked start");

        // R3: maximum payload length
        mem[32'h2000 >> 2] = 32'hFF_800000;
        for (int j = 1; j <= 255; j++) mem[(32'h2000 >> 2) + j] = 32'hAB00_0000 + 32'(j);
        run(24'h002000, "len255");

        // R5: direct two-node cycle
        mem[32'h100 >> 2] = 32'h01_000200;
        mem[32'h200 >> 2] = 32'h02_000100;
        run(24'h000100, "two-cycle");

        // Sweep: placement x length x loopback (R3-R7)
        for (int kind = 0; kind < 3; kind++)
            for (int n = 1; n <= 8; n++)
                for (int lb = 0; lb < 2; lb++) begin
                    for (int i = 0; i < n; i++) begin
                        logic [23:0] a, nx;
                        int len;
                        a = slot_addr(kind, i, n);
                        len = (i * 3 + n) % 8;
                        if (i < n - 1) nx = slot_addr(kind, i + 1, n);
                        else if (lb == 1) nx = slot_addr(kind, n / 2, n);
                        else nx = 24'h800000 | 24'(n * 32'h111);
                        mem[a >> 2] = {8'(len), nx};
                        for (int j = 1; j <= len; j++)
                            mem[(a >> 2) + 24'(j)] = {8'(kind), 8'(n), 8'(i), 8'(j)};
                    end
                    run(slot_addr(kind, 0, n), $sformatf("sweep k%0d n%0d lb%0d", kind, n, lb));
                end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule